// File: doc/BRIEF.md
# Prime-Modulo Interleaved Bank Mapper

This block spreads a flat word address space over a prime number of memory banks. The bank count has the form 2^k − 1 and the depth of each bank is a power of two. The two counts share no factor, so the bank index can be the address modulo the bank count while the in-bank location is the address modulo the depth. Every address inside the capacity then lands on its own (bank, location) pair, and strided access patterns that would keep hitting one bank under low-order interleaving are spread out. The bank index is formed by folding k-bit slices of the address together, with no divider.

Each accepted request keeps its bank occupied for a fixed number of cycles. Requests to other idle banks go on being accepted in the following cycles, so accesses overlap. A request to a bank that is still occupied is held off through the ready signal. An address at or beyond the capacity is consumed at once, raises an error pulse and touches nothing. The storage is a behavioural array inside the block. Each completed access returns one response carrying the bank number and the data word.

Top module: `prime_bank_mapper`

## Requirements
- R1: The bank chosen for an in-range address is the address modulo BANKS = 2^BANK_K − 1 (default 3). The chosen bank appears as bit `bank` of the one-hot `bank_en`.
- R2: The in-bank location is the address modulo DEPTH = 2^DEPTH_LOG2 (default 8), which is the low DEPTH_LOG2 address bits. It is driven on `bank_addr`.
- R3: Each address from 0 to BANKS·DEPTH − 1 (default 0 to 23) reaches a distinct storage word. After all of them have been written with different values, reading each one back returns its own value.
- R4: An address at or above BANKS·DEPTH is accepted at once (`req_ready` high), even when the bank it would fold to is busy. `req_err` is high in the cycle after the acceptance edge. No `bank_en` bit rises, no response follows, and the storage is not changed.
- R5: In the cycle after the edge that accepts an in-range request, and only in that cycle, `bank_en` is one-hot for the target bank and `bank_addr` holds the in-bank location.
- R6: A request accepted at edge E yields `rsp_valid` high for exactly one cycle, right after edge E + BUSY_CYC (default 10). `rsp_bank` carries the bank. `rsp_rdata` carries the stored word: after a write this is the written data, and after reset it is 0.
- R7: A bank accepted at edge E refuses further in-range requests (`req_ready` low while one targets it) until edge E + BUSY_CYC + 1. The earliest re-acceptance is therefore 11 edges later by default.
- R8: In-range requests to different idle banks are accepted on consecutive edges. A three-word block at addresses 0, 1, 2 is accepted on three consecutive edges and returns on three consecutive cycles.
- R9: After reset, `req_ready` is high, and `bank_en`, `req_err` and `rsp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A request is presented |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (5) | Linear word address |
| req_wdata | input | DATA_W (16) | Write data |
| req_ready | output | 1 | Request consumed at this edge if valid |
| req_err | output | 1 | Previous accepted address was beyond capacity |
| bank_en | output | BANKS (3) | One-hot bank enable, one cycle per access |
| bank_addr | output | DEPTH_LOG2 (3) | In-bank location of the latest access |
| rsp_valid | output | 1 | Completion strobe |
| rsp_bank | output | BANK_K (2) | Bank that completed |
| rsp_rdata | output | DATA_W (16) | Stored word at the completed location |

## Verification
The assertions assume that at most one request is taken per edge. They also assume that `req_valid` and the request fields stay steady from the cycle a request is presented until it is consumed. Under these conditions two banks can never finish on the same edge, so one response port is enough. The bench meets these assumptions by driving every request from a single task that changes inputs only at falling edges and holds them until `req_ready` has been seen high. Random addresses are drawn slightly past the capacity so that the error path is mixed with ordinary traffic.

// File: rtl/prime_bank_mapper.sv
module prime_bank_mapper #(
  parameter int BANK_K     = 2,
  parameter int DEPTH_LOG2 = 3,
  parameter int DATA_W     = 16,
  parameter int BUSY_CYC   = 10,
  localparam int BANKS     = (1 << BANK_K) - 1,
  localparam int DEPTH     = 1 << DEPTH_LOG2,
  localparam int CAP       = BANKS * DEPTH,
  localparam int AW        = $clog2(CAP)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [AW-1:0]         req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  output logic                  req_ready,
  output logic                  req_err,
  output logic [BANKS-1:0]      bank_en,
  output logic [DEPTH_LOG2-1:0] bank_addr,
  output logic                  rsp_valid,
  output logic [BANK_K-1:0]     rsp_bank,
  output logic [DATA_W-1:0]     rsp_rdata
);
  localparam int CW = $clog2(BUSY_CYC + 1);
  localparam int SW = AW + 2;
  localparam int NB2 = 1 << BANK_K;
  localparam logic [SW-1:0] KMASK = SW'(NB2 - 1);
  localparam logic [AW:0] CAP_V = (AW + 1)'(CAP);

  // residue modulo 2^k-1: k-bit slices are summed, since 2^k is 1 modulo the count
  function automatic logic [BANK_K-1:0] fold_mod(input logic [AW-1:0] a);
    logic [SW-1:0] s;
    s = {2'b00, a};
    for (int i = 0; i < AW; i++) s = (s & KMASK) + (s >> BANK_K);
    if (s == KMASK) s = '0;
    return s[BANK_K-1:0];
  endfunction

  logic [BANK_K-1:0]     tgt_bank;
  logic [DEPTH_LOG2-1:0] tgt_off;
  logic                  in_range, accept;
  logic [NB2-1:0]        busy_v, done_v;
  logic [CW-1:0]         cnt_q [BANKS];
  logic [DEPTH_LOG2-1:0] off_q [BANKS];
  logic [DATA_W-1:0]     mem_q [BANKS][DEPTH];
  logic [BANK_K-1:0]     done_idx;

  assign tgt_bank  = fold_mod(req_addr);
  assign tgt_off   = req_addr[DEPTH_LOG2-1:0];
  assign in_range  = {1'b0, req_addr} < CAP_V;
  assign req_ready = !in_range || !busy_v[tgt_bank];
  assign accept    = req_valid && req_ready && in_range;

  assign busy_v[NB2-1] = 1'b0;
  assign done_v[NB2-1] = 1'b0;

  for (genvar g = 0; g < BANKS; g++) begin : g_bank
    assign busy_v[g] = cnt_q[g] != '0;
    assign done_v[g] = cnt_q[g] == CW'(1);

    a_r5_en_loads_timer: assert property (@(posedge clk) disable iff (!rst_n)
      bank_en[g] |-> cnt_q[g] == CW'(BUSY_CYC));
    a_r7_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
      bank_en[g] |=> !bank_en[g]);
    a_r7_timer_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q[g] <= CW'(BUSY_CYC));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < BANKS; b++) begin
        cnt_q[b] <= '0;
        off_q[b] <= '0;
      end
    end else begin
      for (int b = 0; b < BANKS; b++) begin
        if (accept && tgt_bank == BANK_K'(b)) begin
          cnt_q[b] <= CW'(BUSY_CYC);
          off_q[b] <= tgt_off;
        end else if (busy_v[b]) begin
          cnt_q[b] <= cnt_q[b] - CW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < BANKS; b++)
        for (int w = 0; w < DEPTH; w++) mem_q[b][w] <= '0;
    end else if (accept && req_write) begin
      mem_q[tgt_bank][tgt_off] <= req_wdata;
    end
  end

  always_comb begin
    done_idx = '0;
    for (int b = 0; b < BANKS; b++)
      if (done_v[b]) done_idx = BANK_K'(b);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_en   <= '0;
      bank_addr <= '0;
      req_err   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_bank  <= '0;
      rsp_rdata <= '0;
    end else begin
      bank_en   <= accept ? (BANKS'(1) << tgt_bank) : '0;
      if (accept) bank_addr <= tgt_off;
      req_err   <= req_valid && !in_range;
      rsp_valid <= |done_v;
      if (|done_v) begin
        rsp_bank  <= done_idx;
        rsp_rdata <= mem_q[done_idx][off_q[done_idx]];
      end
    end
  end

  a_r5_onehot_en: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_en));
  a_r4_err_no_en: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> bank_en == '0);
  a_r6_rsp_bank_free: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !busy_v[rsp_bank]);
  a_r1_rsp_bank_range: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> 32'(rsp_bank) < BANKS);
endmodule

// File: tb/test_prime_bank_mapper.sv
`timescale 1ns/1ps
module test_prime_bank_mapper;
  localparam int BANKS = 3, DEPTH = 8, CAP = 24, BUSY = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [4:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, req_err, rsp_valid;
  logic [2:0]  bank_en, bank_addr;
  logic [1:0]  rsp_bank;
  logic [15:0] rsp_rdata;

  prime_bank_mapper i_prime_bank_mapper (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .req_err(req_err), .bank_en(bank_en), .bank_addr(bank_addr),
    .rsp_valid(rsp_valid), .rsp_bank(rsp_bank), .rsp_rdata(rsp_rdata));

  always #2 clk = ~clk;

  int checks = 0, fails = 0, edge_n = 0;
  logic [15:0] model [CAP];
  bit          pend_v [BANKS];
  int          pend_due [BANKS];
  logic [15:0] pend_data [BANKS];
  int          acc_edge = -1, acc_addr = 0;
  bit          acc_err = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    edge_n <= edge_n + 1;
    if (edge_n > 150000) begin
      checks++; fails++;
      $display("FAIL R7 watchdog actual=%0d expected=%0d", edge_n, 150000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // issue one request; called at a falling edge, returns at a falling edge
  task automatic issue(bit w, int a, logic [15:0] d, output int e);
    req_valid = 1'b1; req_write = w; req_addr = 5'(a); req_wdata = d;
    #1;
    while (!req_ready) begin
      @(negedge clk); #1;
    end
    e = edge_n + 1;
    acc_edge = e; acc_addr = a; acc_err = (a >= CAP);
    if (a < CAP) begin
      if (w) model[a] = d;
      pend_v[a % BANKS] = 1'b1;
      pend_due[a % BANKS] = e + BUSY;
      pend_data[a % BANKS] = model[a];
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // per-cycle output checks against the bench model
  always @(negedge clk) begin
    if (rst_n) begin
      bit found;
      if (edge_n == acc_edge && !acc_err) begin
        chk(bank_en == 3'(1 << (acc_addr % BANKS)), "R1/R5", "bank_en",
            int'(bank_en), 1 << (acc_addr % BANKS));
        chk(bank_addr == 3'(acc_addr % DEPTH), "R2", "bank_addr",
            int'(bank_addr), acc_addr % DEPTH);
        chk(!req_err, "R4", "req_err on in-range", int'(req_err), 0);
      end else if (edge_n == acc_edge && acc_err) begin
        chk(req_err && bank_en == '0, "R4", "err pulse/no enable",
            int'({req_err, bank_en}), 8);
      end else begin
        chk(bank_en == '0 && !req_err, "R5", "idle enables",
            int'({req_err, bank_en}), 0);
      end
      found = 0;
      for (int b = 0; b < BANKS; b++) begin
        if (pend_v[b] && pend_due[b] == edge_n) begin
          found = 1;
          pend_v[b] = 1'b0;
          chk(rsp_valid, "R6", "rsp_valid", int'(rsp_valid), 1);
          chk(rsp_bank == 2'(b), "R6", "rsp_bank", int'(rsp_bank), b);
          chk(rsp_rdata == pend_data[b], "R3/R6", "rsp_rdata",
              int'(rsp_rdata), int'(pend_data[b]));
        end
      end
      if (!found) chk(!rsp_valid, "R6", "spurious rsp", int'(rsp_valid), 0);
    end
  end

  initial begin
    int e0, e1, e2;
    void'($urandom(32'd20240917));
    for (int i = 0; i < CAP; i++) model[i] = '0;
    for (int b = 0; b < BANKS; b++) pend_v[b] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(req_ready && bank_en == '0 && !req_err && !rsp_valid, "R9", "reset state",
        int'({req_ready, req_err, rsp_valid, bank_en}), 32);
    @(negedge clk);
    issue(0, 5, '0, e0);   // R9: location reads 0 after reset
    idle(14);

    // R8: three-word block across three banks
    issue(0, 0, '0, e0); issue(0, 1, '0, e1); issue(0, 2, '0, e2);
    chk(e1 == e0 + 1 && e2 == e1 + 1, "R8", "consecutive accepts", e2 - e0, 2);
    idle(14);

    // R7: same bank twice
    issue(1, 0, 16'h1111, e0); issue(0, 3, '0, e1);
    chk(e1 == e0 + BUSY + 1, "R7", "same-bank spacing", e1 - e0, BUSY + 1);
    idle(14);

    // R4: out-of-range accepted while folded bank busy
    issue(1, 6, 16'h2222, e0); issue(1, 24, 16'hdead, e1);
    chk(e1 == e0 + 1, "R4", "overflow not stalled", e1 - e0, 1);
    issue(1, 31, 16'hbeef, e2);
    idle(14);
    issue(0, 0, '0, e0);   // R4: storage unchanged by the rejected writes
    idle(14);

    // R3: fill every address with a distinct value, read back in reverse
    for (int a = 0; a < CAP; a++) issue(1, a, 16'(16'h0a00 + a * 37), e0);
    idle(14);
    for (int a = CAP - 1; a >= 0; a--) issue(0, a, '0, e0);
    idle(14);

    // random traffic, some addresses past capacity
    for (int n = 0; n < 400; n++) begin
      int a;
      a = int'($urandom_range(0, 27));
      issue(1'($urandom_range(0, 1)), a, 16'($urandom), e0);
      if ($urandom_range(0, 5) == 0) idle(int'($urandom_range(1, 4)));
    end
    idle(16);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule